// File: doc/BRIEF.md
# Daisy-Chain Serial Command Interface

This block is the front end of a chained serial command link. A host drives a serial clock, a load strobe and a serial data line. The block samples all three pins in its own faster system clock. It assembles the bits clocked in while load is low and, when load rises, turns the frame into either a one-cycle register write strobe with a 6-bit address and 8-bit data, or a one-cycle read request. The register storage sits outside the block. For a read, the block takes the addressed byte from that storage and shifts it out on the serial data output, most significant bit first. The host clocks out this byte with further serial clock edges while it keeps load high.

Outside a read, the serial output repeats the serial input delayed by exactly sixteen serial clock edges. Several devices can therefore share the clock and load lines, with each data output wired to the next device's data input. To reach a device further along the chain, the host appends no-operation frames (address 0) behind the command meant for that device. The system clock must run at least four times faster than the serial clock.

Top module: `sci_chain_if`

## Requirements
- R1: Bits are shifted in on each serial clock rising edge while load is low, most significant bit first. A frame is 16 bits. Bit 15 is ignored, bit 14 selects read (1) or write (0), bits 13:8 hold the address and bits 7:0 hold the data.
- R2: On a load rising edge, a write strobe `wr_en` is issued for exactly one system clock cycle when all of the following hold: the number of bits received since load fell is a nonzero multiple of 16, bit 14 of the last 16 bits is 0, and the address is nonzero. `wr_addr` and `wr_data` are taken from those last 16 bits.
- R3: A write frame whose address field is 0 is a no-operation and produces no write strobe.
- R4: A frame whose bit count is neither a nonzero multiple of 16 nor exactly 8 is discarded, with no write strobe and no read request.
- R5: A frame of exactly 8 bits whose bit 6 is 1 raises `rd_req` for one cycle, with `rd_addr` taken from bits 5:0. A 16-bit frame with bit 14 set raises neither strobe. `wr_en` and `rd_req` are never high together.
- R6: After a read request, each serial clock rising edge with load held high presents the next bit of `rd_data` on `ser_dout`, starting with bit 7 and ending with bit 0. `rd_data` is sampled while `rd_req` is high.
- R7: Outside a read, after each serial clock rising edge `ser_dout` shows the bit that entered on the edge 16 rises earlier. `ser_dout` changes only after a serial clock rising edge.
- R8: Reset clears both strobes, drives `ser_dout` low and fills the delay path with zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock |
| ser_ld | input | 1 | Load strobe; low while a frame is shifted in |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out (chain delay or read data) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 6 | Write address |
| wr_data | output | 8 | Write data |
| rd_req | output | 1 | One-cycle register read request |
| rd_addr | output | 6 | Read address |
| rd_data | input | 8 | Addressed register byte, valid while rd_req is high |

## Verification
The read shift-out and the chain delay both act on the same serial clock rising edge, because during a read every edge advances the delay line and also drives the output register. The bench provokes this by running two reads back to back, then a 32-bit chain frame. The read bits must come out in order from bit 7 down to bit 0. The edges after that must show the chain input delayed by exactly sixteen edges, which shows that the read did not disturb how the delay path is counted.

// File: rtl/sci_pkg.sv
package sci_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2
  } sci_cmd_e;

  localparam int PIN_SCLK = 0;
  localparam int PIN_LD   = 1;
  localparam int PIN_DIN  = 2;
  localparam int PIN_CNT  = 3;

endpackage

// File: rtl/sci_pin_sync.sv
module sci_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_pin
      logic [STAGES:0] pipe_q;
      logic [STAGES:0] pipe_d;

      always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], async_i[g]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q <= '0;
        end else begin
          pipe_q <= pipe_d;
        end
      end

      assign level_o[g] = pipe_q[STAGES-1];
      assign rise_o[g]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
      assign fall_o[g]  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
  endgenerate

endmodule

// File: rtl/sci_frame_rx.sv
module sci_frame_rx
  import sci_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              ld_level,
  input  logic              ld_rise,
  input  logic              ld_fall,
  input  logic              din,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr
);

  localparam int CNT_W     = $clog2(FRAME_W);
  localparam int RD_W      = FRAME_W / 2;
  localparam int RW_BIT    = FRAME_W - 2;
  localparam int RD_RW_BIT = RD_W - 2;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_RD   = CNT_W'(RD_W);

  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               full_q, full_d;
  logic [CNT_W-1:0]   cnt_base;
  logic               full_base;
  logic               shift_en;

  sci_cmd_e           cmd_d;
  logic [ADDR_W-1:0]  addr_d;
  logic [DATA_W-1:0]  data_d;
  logic               wr_en_q;
  logic               rd_req_q;
  logic [ADDR_W-1:0]  wr_addr_q, rd_addr_q;
  logic [DATA_W-1:0]  wr_data_q;
  logic               cmd_upd;

  // frame assembly
  always_comb begin
    shift_en  = sclk_rise & ~ld_level;
    cnt_base  = ld_fall ? '0 : cnt_q;
    full_base = ld_fall ? 1'b0 : full_q;
    shreg_d   = shreg_q;
    cnt_d     = cnt_base;
    full_d    = full_base;
    if (shift_en) begin
      shreg_d = {shreg_q[FRAME_W-2:0], din};
      if (cnt_base == CNT_LAST) begin
        cnt_d  = '0;
        full_d = 1'b1;
      end else begin
        cnt_d  = cnt_base + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
    end
  end

  // command decode on load rising edge
  always_comb begin
    cmd_d  = CMD_NONE;
    addr_d = '0;
    data_d = shreg_q[DATA_W-1:0];
    if (ld_rise) begin
      if (full_q && (cnt_q == '0) && !shreg_q[RW_BIT]) begin
        addr_d = shreg_q[DATA_W +: ADDR_W];
        if (addr_d != '0) begin
          cmd_d = CMD_WRITE;
        end
      end else if (!full_q && (cnt_q == CNT_RD) && shreg_q[RD_RW_BIT]) begin
        addr_d = shreg_q[ADDR_W-1:0];
        cmd_d  = CMD_READ;
      end
    end
    cmd_upd = (cmd_d != CMD_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q  <= 1'b0;
      rd_req_q <= 1'b0;
    end else begin
      wr_en_q  <= (cmd_d == CMD_WRITE);
      rd_req_q <= (cmd_d == CMD_READ);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
      wr_data_q <= '0;
      rd_addr_q <= '0;
    end else if (cmd_upd) begin
      if (cmd_d == CMD_WRITE) begin
        wr_addr_q <= addr_d;
        wr_data_q <= data_d;
      end else begin
        rd_addr_q <= addr_d;
      end
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign rd_req  = rd_req_q;
  assign rd_addr = rd_addr_q;

endmodule

// File: rtl/sci_dout_path.sv
module sci_dout_path #(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              ld_fall,
  input  logic              din,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_data,
  output logic              dout
);

  localparam int RCNT_W = $clog2(DATA_W + 1);
  localparam logic [RCNT_W-1:0] RCNT_FULL = RCNT_W'(DATA_W);

  logic [FRAME_W-1:0] dline_q, dline_d;
  logic [DATA_W-1:0]  rsr_q, rsr_d;
  logic [RCNT_W-1:0]  rcnt_q, rcnt_d;
  logic               dout_q, dout_d;
  logic               rd_active;

  assign rd_active = (rcnt_q != '0);

  always_comb begin
    dline_d = dline_q;
    rsr_d   = rsr_q;
    rcnt_d  = rcnt_q;
    dout_d  = dout_q;
    if (rd_load) begin
      rsr_d  = rd_data;
      rcnt_d = RCNT_FULL;
    end else if (ld_fall) begin
      rcnt_d = '0;
    end
    if (sclk_rise) begin
      dline_d = {dline_q[FRAME_W-2:0], din};
      if (rd_active && !ld_fall) begin
        dout_d = rsr_q[DATA_W-1];
        rsr_d  = {rsr_q[DATA_W-2:0], 1'b0};
        rcnt_d = rcnt_q - 1'b1;
      end else begin
        dout_d = dline_q[FRAME_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dline_q <= '0;
      rsr_q   <= '0;
      rcnt_q  <= '0;
      dout_q  <= 1'b0;
    end else begin
      dline_q <= dline_d;
      rsr_q   <= rsr_d;
      rcnt_q  <= rcnt_d;
      dout_q  <= dout_d;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/sci_chain_if.sv
module sci_chain_if
  import sci_pkg::*;
#(
  parameter int FRAME_W     = 16,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_ld,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_core_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[RST_STAGES-1];

  logic [PIN_CNT-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
  logic               sclk_rise, ld_level, ld_rise, ld_fall, din_s;
  logic               unused_edges;

  assign pin_raw[PIN_SCLK] = ser_clk;
  assign pin_raw[PIN_LD]   = ser_ld;
  assign pin_raw[PIN_DIN]  = ser_din;

  sci_pin_sync #(
    .WIDTH  (PIN_CNT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (pin_raw),
    .level_o (pin_lvl),
    .rise_o  (pin_rise),
    .fall_o  (pin_fall)
  );

  assign sclk_rise = pin_rise[PIN_SCLK];
  assign ld_level  = pin_lvl[PIN_LD];
  assign ld_rise   = pin_rise[PIN_LD];
  assign ld_fall   = pin_fall[PIN_LD];
  assign din_s     = pin_lvl[PIN_DIN];
  assign unused_edges = pin_lvl[PIN_SCLK] ^ pin_fall[PIN_SCLK] ^
                        pin_rise[PIN_DIN] ^ pin_fall[PIN_DIN];

  sci_frame_rx #(
    .FRAME_W (FRAME_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sclk_rise (sclk_rise),
    .ld_level  (ld_level),
    .ld_rise   (ld_rise),
    .ld_fall   (ld_fall),
    .din       (din_s),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr)
  );

  sci_dout_path #(
    .FRAME_W (FRAME_W),
    .DATA_W  (DATA_W)
  ) u_dout (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sclk_rise (sclk_rise),
    .ld_fall   (ld_fall),
    .din       (din_s),
    .rd_load   (rd_req),
    .rd_data   (rd_data),
    .dout      (ser_dout)
  );

endmodule

// File: rtl/sci_chain_if_chk.sv
module sci_chain_if_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              ld_rise,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_req,
  input logic              ser_dout
);

  AST_WR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(ld_rise)); // R2

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R2

  AST_NOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr != '0)); // R3

  AST_RD_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> $past(ld_rise)); // R5

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_req); // R5

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(ser_dout)); // R7

endmodule

bind sci_chain_if sci_chain_if_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .sclk_rise (sclk_rise),
  .ld_rise   (ld_rise),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .rd_req    (rd_req),
  .ser_dout  (ser_dout)
);

// File: tb/sci_chain_if_tb_top.sv
module sci_chain_if_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int NVEC       = 8;

  typedef struct packed {
    logic [31:0] bits;
    logic [5:0]  n;
    logic        wr;
    logic [5:0]  a;
    logic [7:0]  d;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_01A5, 6'd16, 1'b1, 6'h01, 8'hA5},  // R2 plain write
    '{32'h0000_8A3C, 6'd16, 1'b1, 6'h0A, 8'h3C},  // R1 bit15 ignored
    '{32'h0000_0000, 6'd16, 1'b0, 6'h00, 8'h00},  // R3 no-op
    '{32'h0000_3F81, 6'd16, 1'b1, 6'h3F, 8'h81},  // R2 top address
    '{32'h0000_2277, 6'd15, 1'b0, 6'h00, 8'h00},  // R4 short
    '{32'h0001_0277, 6'd17, 1'b0, 6'h00, 8'h00},  // R4 long
    '{32'h0000_4155, 6'd16, 1'b0, 6'h00, 8'h00},  // R5 16-bit read ignored
    '{32'h0277_0512, 6'd32, 1'b1, 6'h05, 8'h12}   // R2 chained frame
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_ld = 1'b1;
  logic       ser_din = 1'b0;
  logic       ser_dout;
  logic       wr_en;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;
  logic       rd_req;
  logic [5:0] rd_addr;
  logic [7:0] rd_data;

  logic [7:0] regs_m [64];
  int         wr_seen = 0;
  int         rd_seen = 0;
  logic [5:0] last_wa, last_ra;
  logic [7:0] last_wd;
  int         total = 0;
  int         fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sci_chain_if dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_ld   (ser_ld),
    .ser_din  (ser_din),
    .ser_dout (ser_dout),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  assign rd_data = regs_m[rd_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) regs_m[i] <= 8'h00;
    end else begin
      if (wr_en) begin
        wr_seen <= wr_seen + 1;
        last_wa <= wr_addr;
        last_wd <= wr_data;
        regs_m[wr_addr] <= wr_data;
      end
      if (rd_req) begin
        rd_seen <= rd_seen + 1;
        last_ra <= rd_addr;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b, output logic q);
    ser_din = b;
    tick(HALF);
    ser_clk = 1'b1;
    tick(HALF);
    q = ser_dout;
    ser_clk = 1'b0;
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    logic q;
    ser_ld = 1'b0;
    tick(HALF);
    for (int i = n - 1; i >= 0; i--) pulse(bits[i], q);
    tick(HALF);
    ser_ld = 1'b1;
    tick(8);
  endtask

  task automatic read_byte(input logic [5:0] a, input logic [7:0] exp);
    int   r0;
    logic q;
    r0 = rd_seen;
    send({24'h0, 2'b01, a}, 8);
    chk("R5 read request count", rd_seen - r0, 1);
    chk("R5 read address", last_ra, a);
    for (int i = 7; i >= 0; i--) begin
      pulse(1'b0, q);
      chk("R6 read bit", q, exp[i]);
    end
    tick(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] chain;
    logic        q;
    int          w0, r0;

    tick(3);
    // R8 reset state
    chk("R8 wr_en at reset", wr_en, 0);
    chk("R8 rd_req at reset", rd_req, 0);
    chk("R8 dout at reset", ser_dout, 0);
    rst_n = 1'b1;
    tick(10);

    for (int v = 0; v < NVEC; v++) begin
      w0 = wr_seen;
      r0 = rd_seen;
      send(VECS[v].bits, int'(VECS[v].n));
      chk("R2/R3/R4 write count", wr_seen - w0, {31'h0, VECS[v].wr});
      chk("R4/R5 no read", rd_seen - r0, 0);
      if (VECS[v].wr) begin
        chk("R1 write address", last_wa, VECS[v].a);
        chk("R1 write data", last_wd, VECS[v].d);
      end
    end

    // R6 reads back to back, then chain delay (R7)
    read_byte(6'h01, 8'hA5);
    read_byte(6'h3F, 8'h81);

    chain = 32'hC3A5_0709;
    ser_ld = 1'b0;
    tick(HALF);
    for (int k = 1; k <= 32; k++) begin
      pulse(chain[32 - k], q);
      if (k > 16) chk("R7 chain delay", q, chain[48 - k]);
    end
    tick(HALF);
    ser_ld = 1'b1;
    tick(8);
    chk("R2 chained write address", last_wa, 6'h07);
    chk("R2 chained write data", last_wd, 8'h09);

    // R8 mid-run reset empties the delay path
    rst_n = 1'b0;
    tick(3);
    chk("R8 dout after reset", ser_dout, 0);
    rst_n = 1'b1;
    tick(10);
    ser_ld = 1'b0;
    tick(HALF);
    for (int k = 0; k < 16; k++) begin
      pulse(1'b1, q);
      chk("R8 zero delay path", q, 0);
    end
    tick(HALF);
    ser_ld = 1'b1;
    tick(8);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule